// File: doc/BRIEF.md
# JTAG Register-Access Port

This block is a serial test access port that reaches an internal configuration register file through a standard four-wire JTAG link. A sixteen-state TAP controller runs on TCK and TMS. It steers TDI through either a 5-bit instruction shift stage or one of several data paths: a 1-bit bypass cell, a 32-bit identification word, a 32-bit user word, an 8-bit address register, and an 8-bit data path. The data path reads or writes the register file entry that the address register points at.

Besides register access, the instruction set carries commands with side effects. Two commands raise single-cycle request strobes, one for a reboot and one for an emergency save. Four commands switch a pair of nested access-mode flags: a flash-page flag and, inside it, a user-flash flag. The register file lives outside the block. Its writes are synchronous: the file stores `rf_wdata` at `rf_addr` on a rising TCK edge while `rf_we` is high. Its reads are combinational: `rf_rdata` must always reflect `rf_addr`.

Top module: `jtag_regport`

## Requirements
- R1: The controller follows the standard 16-state TAP graph on rising TCK. Five consecutive rising edges with TMS high reach Test-Logic-Reset from any state.
- R2: In Capture-IR the instruction shift stage loads the constant 5'b00001. In Shift-IR it shifts toward TDO, least significant bit first, so the first scan after reset returns 5'b00001.
- R3: Instruction effects appear only after Update-IR. While an instruction is being shifted, and while the controller sits in Exit1-IR, the mode flags keep their old values.
- R4: Code 5'h1F selects a 1-bit bypass path that captures 0. Every code with no listed meaning does the same. A scan of N bits therefore returns 0 followed by the first N-1 input bits.
- R5: Code 5'h00 selects the 32-bit identification word, which is 32'h4B172E0D by default. Code 5'h03 selects the 32-bit user word, which is 32'hC0DE0042 by default. Both are shifted out least significant bit first.
- R6: Under code 5'h04, an 8-bit scan captures the current address and loads the shifted byte into the address on the falling edge in Update-DR. `rf_addr` does not change while the scan is shifting.
- R7: Under code 5'h05, Capture-DR loads `rf_rdata` at the current address, and the scan returns that byte.
- R8: Under code 5'h06, `rf_we` is high only during the Update-DR cycle. In that cycle `rf_wdata` holds the shifted byte and `rf_addr` holds the current address. Under every other code, `rf_we` stays low in Update-DR.
- R9: The flags change on the rising edge that leaves Update-IR. Code 5'h09 sets `fpg_on`. Code 5'h0A clears both flags. Code 5'h0B sets `ufl_on` only when `fpg_on` is already set. Code 5'h0C clears `ufl_on` and leaves `fpg_on` set.
- R10: With code 5'h07 current, `reboot_req` is high for exactly one TCK cycle on entry to Run-Test/Idle. With code 5'h08 current, `save_req` behaves the same way. The two strobes are never high together.
- R11: Test-Logic-Reset clears both flags and makes the identification word the current selection. This holds whether it is reached by `trst_n` low (asynchronous) or by TMS.
- R12: TDO and `tdo_en` change on falling TCK. `tdo_en` is high only in Shift-IR and Shift-DR, and low in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | TDO drive enable |
| rf_addr | output | 8 | Register file address |
| rf_wdata | output | 8 | Register file write data |
| rf_we | output | 1 | Register file write strobe |
| rf_rdata | input | 8 | Register file read data for rf_addr |
| fpg_on | output | 1 | Flash-page access mode flag |
| ufl_on | output | 1 | User-flash access mode flag |
| reboot_req | output | 1 | One-cycle reboot request |
| save_req | output | 1 | One-cycle emergency-save request |

## Verification
The assertions assume that TMS and TDI are stable around each rising TCK edge. They also assume that `rf_rdata` settles combinationally from `rf_addr` before the Capture-DR edge, and that `trst_n` is released away from a clock edge. The bench meets these conditions as follows. It changes TMS and TDI one nanosecond after each falling edge and releases reset at the same point. It models the register file as an array read directly by `rf_addr` and written on rising TCK. It reads TDO, the flags and the strobes one nanosecond after the edge that updates them.

// File: rtl/jrp_pkg.sv
package jrp_pkg;

   localparam int IR_W = 5;

   localparam logic [IR_W-1:0] OP_BYPASS  = 5'h1F;
   localparam logic [IR_W-1:0] OP_IDENT   = 5'h00;
   localparam logic [IR_W-1:0] OP_USER    = 5'h03;
   localparam logic [IR_W-1:0] OP_SETADR  = 5'h04;
   localparam logic [IR_W-1:0] OP_RDREG   = 5'h05;
   localparam logic [IR_W-1:0] OP_WRREG   = 5'h06;
   localparam logic [IR_W-1:0] OP_REBOOT  = 5'h07;
   localparam logic [IR_W-1:0] OP_SAVE    = 5'h08;
   localparam logic [IR_W-1:0] OP_FPG_ON  = 5'h09;
   localparam logic [IR_W-1:0] OP_FPG_OFF = 5'h0A;
   localparam logic [IR_W-1:0] OP_UFL_ON  = 5'h0B;
   localparam logic [IR_W-1:0] OP_UFL_OFF = 5'h0C;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
   } tap_e;

   typedef enum logic [2:0] {
      DR_BYP, DR_ID, DR_USER, DR_ADR, DR_DAT
   } dsel_e;

   function automatic tap_e tap_next(input tap_e s, input logic m);
      tap_e n;
      case (s)
         ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
         ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: n = m ? ST_UPD_DR : ST_PA_DR;
         ST_PA_DR:  n = m ? ST_EX2_DR : ST_PA_DR;
         ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: n = m ? ST_UPD_IR : ST_PA_IR;
         ST_PA_IR:  n = m ? ST_EX2_IR : ST_PA_IR;
         ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
         default:   n = ST_RESET;
      endcase
      return n;
   endfunction

   function automatic dsel_e dr_select(input logic [IR_W-1:0] op);
      dsel_e d;
      case (op)
         OP_IDENT:           d = DR_ID;
         OP_USER:            d = DR_USER;
         OP_SETADR:          d = DR_ADR;
         OP_RDREG, OP_WRREG: d = DR_DAT;
         default:            d = DR_BYP;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/jrp_tap_fsm.sv
module jrp_tap_fsm
   import jrp_pkg::*;
(
   input  logic tck,
   input  logic trst_n,
   input  logic tms,
   output tap_e state,
   output tap_e nxt
);

   assign nxt = tap_next(state, tms);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_RESET;
      else         state <= nxt;
   end

   // checker: run of consecutive TMS-high edges, saturating at five
   logic [2:0] ones_cnt;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)              ones_cnt <= 3'd0;
      else if (!tms)            ones_cnt <= 3'd0;
      else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
   end

   // R1
   five_ones_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (ones_cnt == 3'd5) |-> (state == ST_RESET));

endmodule

// File: rtl/jrp_ir.sv
module jrp_ir
   import jrp_pkg::*;
#(
   parameter logic [IR_W-1:0] CAPTURE = 5'b00001
)(
   input  logic            tck,
   input  logic            trst_n,
   input  tap_e            state,
   input  logic            tdi,
   output logic [IR_W-1:0] ir_q,
   output logic            ir_lsb
);

   logic [IR_W-1:0] ir_sh;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                 ir_sh <= CAPTURE;
      else if (state == ST_CAP_IR) ir_sh <= CAPTURE;
      else if (state == ST_SH_IR)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
   end

   // parallel latch follows the shift stage only on falling TCK in Update-IR
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)                 ir_q <= OP_IDENT;
      else if (state == ST_RESET)  ir_q <= OP_IDENT;
      else if (state == ST_UPD_IR) ir_q <= ir_sh;
   end

   assign ir_lsb = ir_sh[0];

   // R3
   ir_hold_in_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_SH_IR && $past(state) == ST_SH_IR) |-> $stable(ir_q));

endmodule

// File: rtl/jrp_dr.sv
module jrp_dr
   import jrp_pkg::*;
#(
   parameter int              ADDR_W    = 8,
   parameter int              DATA_W    = 8,
   parameter int              ID_W      = 32,
   parameter logic [ID_W-1:0] ID_CODE   = 32'h4B17_2E0D,
   parameter logic [ID_W-1:0] USER_CODE = 32'hC0DE_0042
)(
   input  logic              tck,
   input  logic              trst_n,
   input  tap_e              state,
   input  logic [IR_W-1:0]   ir_q,
   input  logic              tdi,
   input  logic [DATA_W-1:0] rf_rdata,
   output logic              dr_lsb,
   output logic [ADDR_W-1:0] rf_addr,
   output logic [DATA_W-1:0] rf_wdata,
   output logic              rf_we
);

   localparam int SH_W  = ID_W;
   localparam int LEN_W = $clog2(SH_W);

   dsel_e             sel;
   logic [SH_W-1:0]   dr_sh;
   logic [SH_W-1:0]   sh_next;
   logic [SH_W-1:0]   cap;
   logic [LEN_W-1:0]  len_m1;
   logic [ADDR_W-1:0] addr_q;

   assign sel = dr_select(ir_q);

   always_comb begin
      cap    = '0;
      len_m1 = '0;
      case (sel)
         DR_ID: begin
            cap    = ID_CODE;
            len_m1 = LEN_W'(ID_W - 1);
         end
         DR_USER: begin
            cap    = USER_CODE;
            len_m1 = LEN_W'(ID_W - 1);
         end
         DR_ADR: begin
            cap[ADDR_W-1:0] = addr_q;
            len_m1          = LEN_W'(ADDR_W - 1);
         end
         DR_DAT: begin
            cap[DATA_W-1:0] = rf_rdata;
            len_m1          = LEN_W'(DATA_W - 1);
         end
         default: begin
            cap    = '0;
            len_m1 = '0;
         end
      endcase
   end

   // TDI enters at the top of the selected path length
   for (genvar i = 0; i < SH_W; i++) begin : g_bit
      logic upper;
      if (i == SH_W - 1) begin : g_top
         assign upper = 1'b0;
      end else begin : g_mid
         assign upper = dr_sh[i+1];
      end
      assign sh_next[i] = (len_m1 == LEN_W'(i)) ? tdi : upper;
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                 dr_sh <= '0;
      else if (state == ST_CAP_DR) dr_sh <= cap;
      else if (state == ST_SH_DR)  dr_sh <= sh_next;
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) addr_q <= '0;
      else if (state == ST_UPD_DR && ir_q == OP_SETADR)
         addr_q <= dr_sh[ADDR_W-1:0];
   end

   assign dr_lsb   = dr_sh[0];
   assign rf_addr  = addr_q;
   assign rf_wdata = dr_sh[DATA_W-1:0];
   assign rf_we    = (state == ST_UPD_DR) && (ir_q == OP_WRREG);

   // R6
   addr_hold_in_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_SH_DR && $past(state) == ST_SH_DR) |-> $stable(rf_addr));

   // R8
   we_single_cycle_chk: assert property (@(posedge tck) disable iff (!trst_n)
      rf_we |=> !rf_we);

endmodule

// File: rtl/jrp_ctl.sv
module jrp_ctl
   import jrp_pkg::*;
(
   input  logic            tck,
   input  logic            trst_n,
   input  tap_e            state,
   input  tap_e            nxt,
   input  logic [IR_W-1:0] ir_q,
   output logic            fpg_on,
   output logic            ufl_on,
   output logic            reboot_req,
   output logic            save_req
);

   logic enter_idle;
   assign enter_idle = (nxt == ST_IDLE) && (state != ST_IDLE);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         fpg_on <= 1'b0;
         ufl_on <= 1'b0;
      end else if (state == ST_RESET) begin
         fpg_on <= 1'b0;
         ufl_on <= 1'b0;
      end else if (state == ST_UPD_IR) begin
         case (ir_q)
            OP_FPG_ON:  fpg_on <= 1'b1;
            OP_FPG_OFF: begin
               fpg_on <= 1'b0;
               ufl_on <= 1'b0;
            end
            OP_UFL_ON:  if (fpg_on) ufl_on <= 1'b1;
            OP_UFL_OFF: ufl_on <= 1'b0;
            default: ;
         endcase
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         reboot_req <= 1'b0;
         save_req   <= 1'b0;
      end else begin
         reboot_req <= enter_idle && (ir_q == OP_REBOOT);
         save_req   <= enter_idle && (ir_q == OP_SAVE);
      end
   end

   // R9
   ufl_nested_chk: assert property (@(posedge tck) disable iff (!trst_n)
      ufl_on |-> fpg_on);

   // R10
   reboot_pulse_chk: assert property (@(posedge tck) disable iff (!trst_n)
      reboot_req |=> !reboot_req);

   // R10
   save_pulse_chk: assert property (@(posedge tck) disable iff (!trst_n)
      save_req |=> !save_req);

   // R10
   req_exclusive_chk: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot0({reboot_req, save_req}));

endmodule

// File: rtl/jtag_regport.sv
module jtag_regport
   import jrp_pkg::*;
#(
   parameter int              ADDR_W     = 8,
   parameter int              DATA_W     = 8,
   parameter int              ID_W       = 32,
   parameter logic [ID_W-1:0] ID_CODE    = 32'h4B17_2E0D,
   parameter logic [ID_W-1:0] USER_CODE  = 32'hC0DE_0042,
   parameter logic [4:0]      IR_CAPTURE = 5'b00001,
   parameter bit              TDO_RETIME = 1'b1
)(
   input  logic              tck,
   input  logic              trst_n,
   input  logic              tms,
   input  logic              tdi,
   output logic              tdo,
   output logic              tdo_en,
   output logic [ADDR_W-1:0] rf_addr,
   output logic [DATA_W-1:0] rf_wdata,
   output logic              rf_we,
   input  logic [DATA_W-1:0] rf_rdata,
   output logic              fpg_on,
   output logic              ufl_on,
   output logic              reboot_req,
   output logic              save_req
);

   if (ID_W < ADDR_W || ID_W < DATA_W) begin : g_bad_width
      $error("jtag_regport: ID_W must cover ADDR_W and DATA_W");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_min
      $error("jtag_regport: widths must be positive");
   end

   tap_e            state;
   tap_e            nxt;
   logic [IR_W-1:0] ir_q;
   logic            ir_lsb;
   logic            dr_lsb;
   logic            tdo_src;
   logic            in_shift;

   jrp_tap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (state),
      .nxt    (nxt)
   );

   jrp_ir #(.CAPTURE(IR_CAPTURE)) u_ir (
      .tck    (tck),
      .trst_n (trst_n),
      .state  (state),
      .tdi    (tdi),
      .ir_q   (ir_q),
      .ir_lsb (ir_lsb)
   );

   jrp_dr #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .ID_W      (ID_W),
      .ID_CODE   (ID_CODE),
      .USER_CODE (USER_CODE)
   ) u_dr (
      .tck      (tck),
      .trst_n   (trst_n),
      .state    (state),
      .ir_q     (ir_q),
      .tdi      (tdi),
      .rf_rdata (rf_rdata),
      .dr_lsb   (dr_lsb),
      .rf_addr  (rf_addr),
      .rf_wdata (rf_wdata),
      .rf_we    (rf_we)
   );

   jrp_ctl u_ctl (
      .tck        (tck),
      .trst_n     (trst_n),
      .state      (state),
      .nxt        (nxt),
      .ir_q       (ir_q),
      .fpg_on     (fpg_on),
      .ufl_on     (ufl_on),
      .reboot_req (reboot_req),
      .save_req   (save_req)
   );

   assign tdo_src  = (state == ST_SH_IR) ? ir_lsb : dr_lsb;
   assign in_shift = (state == ST_SH_IR) || (state == ST_SH_DR);

   if (TDO_RETIME) begin : g_tdo_neg
      always_ff @(negedge tck or negedge trst_n) begin
         if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
         end else begin
            tdo    <= tdo_src;
            tdo_en <= in_shift;
         end
      end
   end else begin : g_tdo_comb
      assign tdo    = tdo_src;
      assign tdo_en = in_shift;
   end

endmodule

// File: tb/jtag_regport_bench.sv
`timescale 1ns/1ps
module jtag_regport_bench;

   localparam logic [31:0] EXP_ID   = 32'h4B17_2E0D;
   localparam logic [31:0] EXP_USER = 32'hC0DE_0042;

   logic       tck = 1'b0;
   logic       trst_n = 1'b0;
   logic       tms = 1'b1;
   logic       tdi = 1'b0;
   logic       tdo, tdo_en, rf_we, fpg_on, ufl_on, reboot_req, save_req;
   logic [7:0] rf_addr, rf_wdata, rf_rdata;

   logic [7:0] mem [256];
   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   // shift-scan observations
   logic       en_seen, all_en, addr_moved, upd_we;
   logic [7:0] upd_wdata, upd_addr;
   logic       rb_idle, sv_idle;

   always #4 tck = ~tck;

   jtag_regport u_jtag_regport (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
      .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_rdata(rf_rdata),
      .fpg_on(fpg_on), .ufl_on(ufl_on), .reboot_req(reboot_req), .save_req(save_req)
   );

   assign rf_rdata = mem[rf_addr];
   always @(posedge tck) if (rf_we) mem[rf_addr] <= rf_wdata;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d, output logic o);
      @(negedge tck);
      #1;
      o       = tdo;
      en_seen = tdo_en;
      tms     = m;
      tdi     = d;
      @(posedge tck);
      #1;
   endtask

   task automatic ir_open();
      logic o;
      step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
   endtask

   task automatic ir_bits(input logic [4:0] op, output logic [4:0] cap);
      logic o;
      for (int i = 0; i < 5; i++) begin
         step(i == 4, op[i], o);
         cap[i] = o;
      end
   endtask

   task automatic ir_close();
      logic o;
      step(1, 0, o);
      step(0, 0, o);
      rb_idle = reboot_req;
      sv_idle = save_req;
   endtask

   task automatic load_ir(input logic [4:0] op, output logic [4:0] cap);
      ir_open();
      ir_bits(op, cap);
      ir_close();
   endtask

   task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
      logic o;
      logic [7:0] a0;
      dout = '0;
      step(1, 0, o); step(0, 0, o); step(0, 0, o);
      a0 = rf_addr;
      all_en = 1'b1;
      addr_moved = 1'b0;
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, din[i], o);
         dout[i] = o;
         all_en = all_en & en_seen;
         if (rf_addr !== a0) addr_moved = 1'b1;
      end
      step(1, 0, o);
      upd_we    = rf_we;
      upd_wdata = rf_wdata;
      upd_addr  = rf_addr;
      step(0, 0, o);
   endtask

   task automatic t_reset();
      logic o;
      trst_n = 1'b0;
      tms = 1'b1;
      repeat (3) @(posedge tck);
      @(negedge tck); #1;
      check("R12 tdo_en in reset", tdo_en, 0);
      check("R11 fpg_on in reset", fpg_on, 0);
      check("R11 ufl_on in reset", ufl_on, 0);
      check("R10 strobes in reset", {reboot_req, save_req}, 0);
      check("R8 rf_we in reset", rf_we, 0);
      trst_n = 1'b1;
      step(0, 0, o);
      step(0, 0, o);
      check("R12 tdo_en idle", en_seen, 0);
   endtask

   task automatic t_idcode();
      logic [31:0] d;
      scan_dr(32, 32'h0, d);
      check("R11 identification after reset", d, EXP_ID);
      check("R12 tdo_en high through Shift-DR", all_en, 1);
   endtask

   task automatic t_ir_capture_user();
      logic [4:0] cap;
      logic [31:0] d;
      load_ir(5'h03, cap);
      check("R2 IR capture constant", {27'h0, cap}, 32'h1);
      scan_dr(32, 32'hFFFF_FFFF, d);
      check("R5 user word", d, EXP_USER);
      load_ir(5'h00, cap);
      scan_dr(32, 32'h0, d);
      check("R5 identification word", d, EXP_ID);
   endtask

   task automatic t_bypass();
      logic [4:0] cap;
      logic [31:0] d;
      load_ir(5'h1F, cap);
      scan_dr(8, 32'hB6, d);
      check("R4 bypass 1F", d, 32'h6C);
      load_ir(5'h15, cap);
      scan_dr(8, 32'h5B, d);
      check("R4 unlisted code 15 bypass", d, 32'hB6);
   endtask

   task automatic t_address_write_read();
      logic [4:0] cap;
      logic [31:0] d;
      load_ir(5'h04, cap);
      scan_dr(8, 32'h5A, d);
      check("R6 address capture returns old address", d, 32'h00);
      check("R6 rf_addr after update", rf_addr, 8'h5A);
      check("R6 rf_addr steady while shifting", addr_moved, 0);
      check("R8 no write under address code", upd_we, 0);
      load_ir(5'h06, cap);
      scan_dr(8, 32'hC3, d);
      check("R8 rf_we in Update-DR", upd_we, 1);
      check("R8 rf_wdata in Update-DR", upd_wdata, 8'hC3);
      check("R8 rf_addr in Update-DR", upd_addr, 8'h5A);
      check("R8 rf_we low after Update-DR", rf_we, 0);
      check("R8 register file written", mem[8'h5A], 8'hC3);
      load_ir(5'h04, cap);
      scan_dr(8, 32'h10, d);
      load_ir(5'h05, cap);
      scan_dr(8, 32'h00, d);
      check("R7 read at 10", d, 32'(8'h10 ^ 8'hA5));
      check("R8 no write under read code", upd_we, 0);
      check("R8 entry untouched by read", mem[8'h10], 8'h10 ^ 8'hA5);
      load_ir(5'h04, cap);
      scan_dr(8, 32'h5A, d);
      load_ir(5'h05, cap);
      scan_dr(8, 32'hFF, d);
      check("R7 read back written byte", d, 32'hC3);
   endtask

   task automatic t_flags();
      logic [4:0] cap;
      load_ir(5'h0B, cap);
      check("R9 user flash refused without flash page", ufl_on, 0);
      ir_open();
      ir_bits(5'h09, cap);
      check("R3 flag unchanged in Exit1-IR", fpg_on, 0);
      ir_close();
      check("R9 flash page on", fpg_on, 1);
      load_ir(5'h0B, cap);
      check("R9 user flash on", ufl_on, 1);
      load_ir(5'h0C, cap);
      check("R9 user flash off clears ufl", ufl_on, 0);
      check("R9 user flash off keeps fpg", fpg_on, 1);
      load_ir(5'h0B, cap);
      load_ir(5'h0A, cap);
      check("R9 flash page off clears both", {fpg_on, ufl_on}, 0);
   endtask

   task automatic t_strobes();
      logic [4:0] cap;
      logic o;
      load_ir(5'h07, cap);
      check("R10 reboot pulse on idle entry", {rb_idle, sv_idle}, 2'b10);
      step(0, 0, o);
      check("R10 reboot pulse lasts one cycle", reboot_req, 0);
      load_ir(5'h08, cap);
      check("R10 save pulse on idle entry", {rb_idle, sv_idle}, 2'b01);
      step(0, 0, o);
      check("R10 save pulse lasts one cycle", save_req, 0);
   endtask

   task automatic t_tms_reset();
      logic [4:0] cap;
      logic [31:0] d;
      logic o;
      load_ir(5'h09, cap);
      load_ir(5'h0B, cap);
      step(1, 0, o); step(0, 0, o); step(0, 0, o);
      for (int i = 0; i < 5; i++) step(1, 0, o);
      step(0, 0, o);
      check("R1 R11 flags cleared by five TMS highs", {fpg_on, ufl_on}, 0);
      scan_dr(32, 32'h0, d);
      check("R1 R11 identification after TMS reset", d, EXP_ID);
   endtask

   task automatic t_async_reset();
      logic [4:0] cap;
      logic [31:0] d;
      logic o;
      load_ir(5'h09, cap);
      load_ir(5'h03, cap);
      @(negedge tck); #2;
      trst_n = 1'b0;
      #1;
      check("R11 async reset clears flag", fpg_on, 0);
      @(negedge tck); #1;
      trst_n = 1'b1;
      tms = 1'b0;
      step(0, 0, o);
      scan_dr(32, 32'h0, d);
      check("R11 identification after async reset", d, EXP_ID);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
      t_reset();
      t_idcode();
      t_ir_capture_user();
      t_bypass();
      t_address_write_read();
      t_flags();
      t_strobes();
      t_tms_reset();
      t_async_reset();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge tck);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule